// File: doc/BRIEF.md
# Microcoded Control Sequencer with Opcode Dispatch

This block is the control unit of a small multicycle processor. A 4-bit micro-program counter selects one word of an internal microcode store. Each word carries two things: a 2-bit sequencing command that chooses the next micro-address, and a 16-bit vector of datapath control points. These control points are driven straight out to the datapath, which is not part of this block. The next address can be one of four things. It can be the fetch entry at address 0. It can be the current address plus one. It can be a dispatch target looked up from the instruction opcode. Or it can be the current address, which holds the counter.

The stored program covers five instruction classes: register-register ALU, OR with an immediate, load, store and branch-if-equal. Every instruction begins with a fetch step that increments and a decode step that dispatches. Each instruction's last step returns to fetch. The steps that access memory are flagged in the microcode. On those steps a high `waitIn` freezes the micro-PC until memory is ready.

Top module: `ucode_sequencer`

## Requirements
- R1: A synchronous active-high `rst` forces the micro-PC to 0, so the fetch control word 0x0003 is presented in the first cycle after reset is released. This holds even when reset is raised in the middle of an instruction.
- R2: The bit positions of `ctrlWord` are: 0 instruction-memory read, 1 instruction-register load, 2 operand-register load, 3 ALU-result load, 4 ALU second operand from immediate, 5 sign-extend immediate, 7:6 ALU function (00 add, 01 or, 10 from function field), 8 data-memory read, 9 memory-data register load, 10 data-memory write, 11 register-file write, 12 destination from rd field, 13 write-back from memory data, 14 PC update, 15 branch target select.
- R3: The fetch step (0x0003) is followed, when not held, by the decode step (0x0004).
- R4: The decode step dispatches on `opcode`. 1 selects the ALU sequence, 2 the OR-immediate sequence, 3 load, 4 store and 5 branch.
- R5: At decode, any opcode without a dispatch entry (including 0) sends the next step back to fetch.
- R6: The ALU sequence is 0x0088 then 0x5800, followed by fetch.
- R7: The OR-immediate sequence is 0x0058 then 0x4800, followed by fetch.
- R8: The load sequence is 0x0038, then 0x0300, then 0x6800, followed by fetch.
- R9: The store sequence is 0x0038 then 0x4400, followed by fetch.
- R10: The branch sequence is a single step 0xC000, followed by fetch.
- R11: On a memory step (fetch, load memory read, store memory write), a high `waitIn` holds the current control word for the next cycle. The hold takes priority over the step's sequencing command and lasts as long as `waitIn` stays high.
- R12: `waitIn` has no effect on steps that do not access memory.
- R13: `opcode` has no effect on any step other than decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| waitIn | input | 1 | Memory not ready; stalls memory steps |
| ctrlWord | output | 16 | Datapath control points of the current microinstruction |

## Verification
The assertions assume that `waitIn` is a settled level at each rising edge. They also assume that `opcode` is stable over the decode cycle, because the dispatch target is sampled only at that edge. The bench changes both inputs only at the falling edge. It raises `waitIn` for several consecutive cycles on memory steps and also on compute steps, where it has to be ignored. It presents nonzero opcodes outside decode to show they have no effect.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

  localparam int OP_W   = 6;
  localparam int UPC_W  = 4;
  localparam int CTRL_W = 16;
  localparam int N_DISP = 5;

  typedef enum logic [1:0] {
    SEQ_ZERO = 2'b00,
    SEQ_DISP = 2'b01,
    SEQ_INC  = 2'b10,
    SEQ_HOLD = 2'b11
  } seq_e;

  // Datapath control points, MSB first so the packed layout equals ctrlWord.
  typedef struct packed {
    logic       brSel;
    logic       pcEn;
    logic       memToReg;
    logic       regDst;
    logic       regWr;
    logic       dmemWr;
    logic       mEn;
    logic       dmemRd;
    logic [1:0] aluOp;
    logic       extSign;
    logic       aluImm;
    logic       sEn;
    logic       opEn;
    logic       irEn;
    logic       imemRd;
  } ctrl_t;

  // Strobes that the store hands to the micro-PC logic.
  typedef struct packed {
    seq_e seq;
    logic memStep;
  } seq_cmd_t;

  typedef struct packed {
    seq_cmd_t cmd;
    ctrl_t    ctrl;
  } uinst_t;

  localparam logic [1:0] ALU_ADD = 2'b00;
  localparam logic [1:0] ALU_OR  = 2'b01;
  localparam logic [1:0] ALU_FUN = 2'b10;

  // Microprogram entry points.
  localparam logic [UPC_W-1:0] A_FETCH = 4'd0;
  localparam logic [UPC_W-1:0] A_DEC   = 4'd1;
  localparam logic [UPC_W-1:0] A_REX   = 4'd2;
  localparam logic [UPC_W-1:0] A_RWB   = 4'd3;
  localparam logic [UPC_W-1:0] A_OEX   = 4'd4;
  localparam logic [UPC_W-1:0] A_OWB   = 4'd5;
  localparam logic [UPC_W-1:0] A_LEX   = 4'd6;
  localparam logic [UPC_W-1:0] A_LMEM  = 4'd7;
  localparam logic [UPC_W-1:0] A_LWB   = 4'd8;
  localparam logic [UPC_W-1:0] A_SEX   = 4'd9;
  localparam logic [UPC_W-1:0] A_SMEM  = 4'd10;
  localparam logic [UPC_W-1:0] A_BR    = 4'd11;

  // Dispatch table: opcode -> first execute step.
  localparam logic [OP_W-1:0]  DISP_OP  [N_DISP] = '{6'd1, 6'd2, 6'd3, 6'd4, 6'd5};
  localparam logic [UPC_W-1:0] DISP_TGT [N_DISP] = '{A_REX, A_OEX, A_LEX, A_SEX, A_BR};

endpackage

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
  import ucode_pkg::*;
(
  input  logic [OP_W-1:0]  opcode,
  output logic [UPC_W-1:0] dispAddr,
  output logic             dispValid
);

  logic [N_DISP-1:0]  hit;
  logic [UPC_W-1:0]   tgtMasked [N_DISP];

  for (genvar i = 0; i < N_DISP; i++) begin : g_entry
    assign hit[i]       = (opcode == DISP_OP[i]);
    assign tgtMasked[i] = hit[i] ? DISP_TGT[i] : '0;
  end

  always_comb begin
    dispAddr = '0;
    for (int i = 0; i < N_DISP; i++) dispAddr |= tgtMasked[i];
  end

  assign dispValid = |hit;

  // Opcodes in the table are distinct, so at most one entry matches (R4).
  always_comb begin
    a_single_hit_r4: assert ($onehot0(hit));
  end

endmodule

// File: rtl/ucode_store.sv
module ucode_store
  import ucode_pkg::*;
(
  input  logic [UPC_W-1:0] uPC,
  output uinst_t           uInst
);

  always_comb begin
    uInst = '0;
    uInst.cmd.seq = SEQ_ZERO;
    unique case (uPC)
      A_FETCH: begin
        uInst.ctrl.imemRd  = 1'b1;
        uInst.ctrl.irEn    = 1'b1;
        uInst.cmd.memStep  = 1'b1;
        uInst.cmd.seq      = SEQ_INC;
      end
      A_DEC: begin
        uInst.ctrl.opEn    = 1'b1;
        uInst.cmd.seq      = SEQ_DISP;
      end
      A_REX: begin
        uInst.ctrl.sEn     = 1'b1;
        uInst.ctrl.aluOp   = ALU_FUN;
        uInst.cmd.seq      = SEQ_INC;
      end
      A_RWB: begin
        uInst.ctrl.regWr   = 1'b1;
        uInst.ctrl.regDst  = 1'b1;
        uInst.ctrl.pcEn    = 1'b1;
      end
      A_OEX: begin
        uInst.ctrl.sEn     = 1'b1;
        uInst.ctrl.aluImm  = 1'b1;
        uInst.ctrl.aluOp   = ALU_OR;
        uInst.cmd.seq      = SEQ_INC;
      end
      A_OWB: begin
        uInst.ctrl.regWr   = 1'b1;
        uInst.ctrl.pcEn    = 1'b1;
      end
      A_LEX, A_SEX: begin
        uInst.ctrl.sEn     = 1'b1;
        uInst.ctrl.aluImm  = 1'b1;
        uInst.ctrl.extSign = 1'b1;
        uInst.ctrl.aluOp   = ALU_ADD;
        uInst.cmd.seq      = SEQ_INC;
      end
      A_LMEM: begin
        uInst.ctrl.dmemRd  = 1'b1;
        uInst.ctrl.mEn     = 1'b1;
        uInst.cmd.memStep  = 1'b1;
        uInst.cmd.seq      = SEQ_INC;
      end
      A_LWB: begin
        uInst.ctrl.regWr    = 1'b1;
        uInst.ctrl.memToReg = 1'b1;
        uInst.ctrl.pcEn     = 1'b1;
      end
      A_SMEM: begin
        uInst.ctrl.dmemWr  = 1'b1;
        uInst.ctrl.pcEn    = 1'b1;
        uInst.cmd.memStep  = 1'b1;
      end
      A_BR: begin
        uInst.ctrl.pcEn    = 1'b1;
        uInst.ctrl.brSel   = 1'b1;
      end
      default: uInst = '0;
    endcase
  end

endmodule

// File: rtl/ucode_upc.sv
module ucode_upc
  import ucode_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             waitIn,
  input  seq_cmd_t         cmd,
  input  logic [UPC_W-1:0] dispAddr,
  input  logic             dispValid,
  output logic [UPC_W-1:0] uPC
);

  logic             holdNow;
  logic [UPC_W-1:0] nextPC;

  assign holdNow = (cmd.memStep && waitIn) || (cmd.seq == SEQ_HOLD);

  always_comb begin
    nextPC = uPC;
    if (!holdNow) begin
      unique case (cmd.seq)
        SEQ_ZERO: nextPC = A_FETCH;
        SEQ_DISP: nextPC = dispValid ? dispAddr : A_FETCH;
        SEQ_INC:  nextPC = uPC + 1'b1;
        default:  nextPC = uPC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) uPC <= A_FETCH;
    else     uPC <= nextPC;
  end

  p_wait_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd.memStep && waitIn) |=> $stable(uPC));

  p_increment_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd.seq == SEQ_INC && !waitIn) |=> (uPC == $past(uPC) + 1'b1));

  p_return_fetch_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd.seq == SEQ_ZERO && !(cmd.memStep && waitIn)) |=> (uPC == A_FETCH));

  p_unknown_op_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd.seq == SEQ_DISP && !dispValid) |=> (uPC == A_FETCH));

  p_dispatch_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd.seq == SEQ_DISP && dispValid) |=> (uPC == $past(dispAddr)));

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic              waitIn,
  output logic [CTRL_W-1:0] ctrlWord
);

  logic [UPC_W-1:0] uPC;
  logic [UPC_W-1:0] dispAddr;
  logic             dispValid;
  uinst_t           uInst;

  ucode_dispatch i_dispatch (
    .opcode    (opcode),
    .dispAddr  (dispAddr),
    .dispValid (dispValid)
  );

  ucode_store i_store (
    .uPC   (uPC),
    .uInst (uInst)
  );

  ucode_upc i_upc (
    .clk       (clk),
    .rst       (rst),
    .waitIn    (waitIn),
    .cmd       (uInst.cmd),
    .dispAddr  (dispAddr),
    .dispValid (dispValid),
    .uPC       (uPC)
  );

  assign ctrlWord = uInst.ctrl;

  // Data memory is never read and written in one step (R2).
  p_mem_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(ctrlWord[8] && ctrlWord[10]));

endmodule

// File: tb/test_ucode_sequencer.sv
module test_ucode_sequencer;

  localparam int CLK_PERIOD = 10;

  // Expected control words, from the bit layout of R2.
  localparam logic [15:0] W_FETCH = 16'h0003;
  localparam logic [15:0] W_DEC   = 16'h0004;
  localparam logic [15:0] W_REX   = 16'h0088;
  localparam logic [15:0] W_RWB   = 16'h5800;
  localparam logic [15:0] W_OEX   = 16'h0058;
  localparam logic [15:0] W_OWB   = 16'h4800;
  localparam logic [15:0] W_AEX   = 16'h0038;
  localparam logic [15:0] W_LMEM  = 16'h0300;
  localparam logic [15:0] W_LWB   = 16'h6800;
  localparam logic [15:0] W_SMEM  = 16'h4400;
  localparam logic [15:0] W_BR    = 16'h C000;

  // Row: {opcode applied after check, waitIn applied after check, expected word}
  localparam int NV = 36;
  localparam logic [22:0] VEC [NV] = '{
    {6'd0, 1'b0, W_FETCH}, {6'd1, 1'b0, W_DEC},             // ALU, R6
    {6'd3, 1'b1, W_REX},   {6'd0, 1'b0, W_RWB},             // R13 op, R12 wait ignored
    {6'd0, 1'b0, W_FETCH}, {6'd2, 1'b0, W_DEC},             // OR-immediate, R7
    {6'd0, 1'b0, W_OEX},   {6'd0, 1'b0, W_OWB},
    {6'd0, 1'b1, W_FETCH}, {6'd0, 1'b1, W_FETCH},           // R11 fetch stall
    {6'd0, 1'b0, W_FETCH}, {6'd3, 1'b0, W_DEC},             // load, R8
    {6'd0, 1'b1, W_AEX},   {6'd0, 1'b1, W_LMEM},            // R12 then R11
    {6'd0, 1'b1, W_LMEM},  {6'd0, 1'b0, W_LMEM},
    {6'd0, 1'b1, W_LWB},                                    // R12
    {6'd5, 1'b0, W_FETCH}, {6'd4, 1'b0, W_DEC},             // R13, store R9
    {6'd0, 1'b0, W_AEX},   {6'd0, 1'b1, W_SMEM},
    {6'd0, 1'b0, W_SMEM},
    {6'd0, 1'b0, W_FETCH}, {6'd5, 1'b0, W_DEC},             // branch R10
    {6'd0, 1'b1, W_BR},                                     // R12
    {6'd0, 1'b0, W_FETCH}, {6'd9, 1'b0, W_DEC},             // R5 unknown opcode
    {6'd0, 1'b0, W_FETCH}, {6'd0, 1'b0, W_DEC},             // R5 opcode 0
    {6'd63, 1'b0, W_FETCH}, {6'd6, 1'b0, W_DEC},            // R5 opcode 6
    {6'd0, 1'b0, W_FETCH}, {6'd1, 1'b0, W_DEC},             // back-to-back ALU
    {6'd0, 1'b0, W_REX},   {6'd0, 1'b0, W_RWB},
    {6'd0, 1'b0, W_FETCH}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  opcode = '0;
  logic        waitIn = 1'b0;
  logic [15:0] ctrlWord;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_sequencer i_ucode_sequencer (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .waitIn   (waitIn),
    .ctrlWord (ctrlWord)
  );

  function automatic string tagOf(input logic [15:0] w);
    case (w)
      W_FETCH:        return "R3";
      W_DEC:          return "R4";
      W_REX, W_RWB:   return "R6";
      W_OEX, W_OWB:   return "R7";
      W_LWB:          return "R8";
      W_LMEM, W_SMEM: return "R11";
      W_AEX:          return "R9";
      W_BR:           return "R10";
      default:        return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] exp);
    nChecks++;
    if (ctrlWord !== exp) begin
      nFails++;
      $display("FAIL %s: ctrlWord=%h expected=%h at %0t", tag, ctrlWord, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nFails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1", W_FETCH);                       // R1 reset state

    for (int i = 0; i < NV; i++) begin
      if (i > 0) @(negedge clk);
      check(tagOf(VEC[i][15:0]), VEC[i][15:0]);
      opcode = VEC[i][22:17];
      waitIn = VEC[i][16];
    end

    // R1: reset raised in the middle of a stalled load memory step.
    @(negedge clk); opcode = 6'd3; waitIn = 1'b0;   // now at decode
    @(negedge clk); check("R8", W_AEX);
    @(negedge clk); check("R8", W_LMEM); waitIn = 1'b1;
    @(negedge clk); check("R11", W_LMEM);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0; waitIn = 1'b0;
    check("R1", W_FETCH);
    opcode = 6'd5;
    @(negedge clk); check("R3", W_DEC);
    @(negedge clk); check("R10", W_BR);
    @(negedge clk); check("R10", W_FETCH);

    // R11: long stall on store write, wait held for many cycles.
    opcode = 6'd4;
    @(negedge clk); check("R4", W_DEC);
    @(negedge clk); check("R9", W_AEX); waitIn = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); check("R11", W_SMEM);
    end
    waitIn = 1'b0;
    @(negedge clk); check("R9", W_FETCH);

    finishRun();
  end

endmodule